// File: doc/BRIEF.md
# Bus Address Recognition Slice

This block is one 16-bit slice of the address recognizer in a backplane bus slave. Two copies are cascaded to cover a 32-bit address. A static strap input sets the role of each copy: lower slice or upper slice. A 5-bit width code divides the slice's 16 address bits into two fields. The low-order internal-address field is ignored during recognition. The remaining device-address field must equal the stored logical-address register.

The lower slice also performs two further checks. The geographic check tests the low data byte against the slot's 5-bit geographic address. The class-N lookup selects one bit of a 16-bit class register, using data bits 7:4 as the index. The upper slice holds both of these outputs at their inactive levels.

All flags are computed combinationally from the current bus data. They model open-collector lines. Outside the block, the logical-address match flags of the two slices are ORed together. The logical-address and class register contents arrive as inputs, because the write paths for those registers sit outside this block.

Top module: `addr_recog_slice`

## Requirements
- R1: With width code 0 the internal-address field is empty, and `lad_match` is 1 exactly when all 16 bits of `bus_data` equal `lad_value`.
- R2: With width code w in 1..15, bits w-1:0 are internal address and are ignored, and bits 15:w are compared. For example, code 4 ignores bits 3:0 and compares bits 15:4.
- R3: Any width code of 16 or more (code bit 4 set) puts all 16 bits in the internal-address field, so `lad_match` is 1 whatever the data and the stored value.
- R4: For every width code, `lad_match` is 1 if and only if every bit at position ≥ width code has `bus_data` equal to `lad_value`.
- R5: On the lower slice (`slice_upper` = 0), `geo_match` is 1 exactly when `bus_data[4:0]` equals `geo_addr` and `bus_data[7:5]` is 000. Bits 15:8 have no effect.
- R6: On the upper slice (`slice_upper` = 1), `geo_match` is 0 for every value of `geo_addr` and `bus_data`.
- R7: On the lower slice, `class_hit_n` is 0 exactly when `class_bits[bus_data[7:4]]` is 1. It is active low.
- R8: On the upper slice, `class_hit_n` is 1 whatever the class register holds.
- R9: Both strap settings apply the same logical-address comparison. When two slices hold the lower and upper halves of a 32-bit address, the OR of their `lad_match` flags is 1 when either slice matches and 0 when neither slice matches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| slice_upper | input | 1 | Static role strap: 0 for the lower slice, 1 for the upper slice |
| bus_data | input | 16 | Address/data bits currently on the internal bus |
| width_code | input | 5 | Internal-address field width; bit n weighs 2^n |
| geo_addr | input | 5 | Slot geographic address (only the lower slice uses it) |
| lad_value | input | 16 | Contents of the stored logical-address register |
| class_bits | input | 16 | Contents of the class-N register |
| lad_match | output | 1 | 1 when the unmasked bits equal the logical address |
| geo_match | output | 1 | 1 on a geographic-address hit (lower slice only) |
| class_hit_n | output | 1 | 0 when the selected class-N bit is set (lower slice only) |

## Verification
The assertions assume that `slice_upper` is a strap that does not move while the data inputs are being evaluated. They also assume that all inputs carry known 0/1 values, because every flag follows the inputs combinationally. The stimulus respects both assumptions. Each instance's strap is wired to a constant. All inputs are driven to defined values at time zero, and are changed only on the rising clock edge. Outputs are sampled at the falling edge, after the inputs have settled.

// File: rtl/addr_recog_pkg.sv
// Package: addr_recog_pkg
// Shared definitions for the address recognition slice.
// Assumes: the strap encoding is 0 for the lower slice and 1 for the upper slice.
package addr_recog_pkg;

    // Role that the static strap gives a slice within the two-slice cascade.
    typedef enum logic {
        ROLE_LOWER = 1'b0,
        ROLE_UPPER = 1'b1
    } slice_role_e;

endpackage

// File: rtl/ars_mask_decode.sv
// Module: ars_mask_decode
// Turns the width code into a thermometer mask of internal-address bits.
// Bit i of the mask is set when i < width_code. The mask therefore becomes
// all ones once the code reaches DATA_W.
// Assumes: width_code is static or slowly varying. The output is purely combinational.
module ars_mask_decode #(
    parameter int DATA_W = 16,
    parameter int CODE_W = 5
) (
    input  logic [CODE_W-1:0] width_code,
    output logic [DATA_W-1:0] ia_mask
);

    // One magnitude compare per bit position builds the thermometer.
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign ia_mask[i] = (32'(width_code) > 32'(i));
    end

endmodule

// File: rtl/ars_lad_compare.sv
// Module: ars_lad_compare
// Compares the device-address bits of the bus with the stored logical address.
// Bits flagged in ia_mask are excluded from the compare.
// Assumes: ia_mask is a thermometer code from ars_mask_decode. Any mask works, though.
module ars_lad_compare #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] bus_data,
    input  logic [DATA_W-1:0] lad_value,
    input  logic [DATA_W-1:0] ia_mask,
    output logic              lad_match
);

    logic [DATA_W-1:0] bit_miss;

    // A bit position misses when it is compared and the two values differ.
    for (genvar i = 0; i < DATA_W; i++) begin : g_cmp
        assign bit_miss[i] = ~ia_mask[i] & (bus_data[i] ^ lad_value[i]);
    end

    // The slice matches when no compared bit misses.
    assign lad_match = ~|bit_miss;

endmodule

// File: rtl/ars_geo_check.sv
// Module: ars_geo_check
// Geographic-address check on the low part of the bus.
// The low GA_W bits must equal geo_addr, and the bits from GA_W up to CHK_W-1 must be zero.
// Assumes: enable is the static lower-slice strap. A disabled slice reports no hit.
module ars_geo_check #(
    parameter int GA_W  = 5,
    parameter int CHK_W = 8
) (
    input  logic             enable,
    input  logic [CHK_W-1:0] data_low,
    input  logic [GA_W-1:0]  geo_addr,
    output logic             geo_hit
);

    localparam int PAD_W = CHK_W - GA_W;

    logic addr_equal;
    logic pad_clear;

    // Equality of the slot-address field.
    assign addr_equal = (data_low[GA_W-1:0] == geo_addr);

    // The bits above the slot field must all be zero.
    assign pad_clear = (data_low[CHK_W-1:GA_W] == {PAD_W{1'b0}});

    // The hit is reported only by an enabled (lower) slice.
    assign geo_hit = enable & addr_equal & pad_clear;

endmodule

// File: rtl/ars_class_select.sv
// Module: ars_class_select
// Selects one bit of the class-N register by an index taken from the bus.
// It reports that bit as an active-low hit.
// Assumes: the class register has exactly 2**SEL_W bits. A disabled slice drives the inactive level (1).
module ars_class_select #(
    parameter int SEL_W = 4
) (
    input  logic                enable,
    input  logic [SEL_W-1:0]    sel,
    input  logic [2**SEL_W-1:0] class_bits,
    output logic                hit_n
);

    logic picked;

    // Pick the indexed class bit.
    assign picked = class_bits[sel];

    // Active-low flag, gated by the slice role.
    assign hit_n = ~(enable & picked);

endmodule

// File: rtl/addr_recog_slice.sv
// Module: addr_recog_slice
// One 16-bit slice of the backplane slave address recognizer.
// It decodes the internal-address width, compares the device-address field with the
// logical-address register, and performs the geographic and class-N checks. The last
// two checks are active only on the lower slice.
// Assumes: slice_upper is a static strap. Register contents arrive as inputs.
// The external wired-OR of the two slices' lad_match flags is outside this block.
module addr_recog_slice #(
    parameter int DATA_W      = 16,
    parameter int CODE_W      = 5,
    parameter int GA_W        = 5,
    parameter int GEO_CHK_W   = 8,
    parameter int CLS_SEL_W   = 4,
    parameter int CLS_SEL_LSB = 4
) (
    input  logic                    slice_upper,
    input  logic [DATA_W-1:0]       bus_data,
    input  logic [CODE_W-1:0]       width_code,
    input  logic [GA_W-1:0]         geo_addr,
    input  logic [DATA_W-1:0]       lad_value,
    input  logic [2**CLS_SEL_W-1:0] class_bits,
    output logic                    lad_match,
    output logic                    geo_match,
    output logic                    class_hit_n
);
    import addr_recog_pkg::*;

    localparam int CLS_SEL_MSB = CLS_SEL_LSB + CLS_SEL_W - 1;

    slice_role_e       role;
    logic              is_lower;
    logic [DATA_W-1:0] ia_mask;

    // Interpret the strap as a slice role.
    assign role     = slice_role_e'(slice_upper);
    assign is_lower = (role == ROLE_LOWER);

    ars_mask_decode #(
        .DATA_W (DATA_W),
        .CODE_W (CODE_W)
    ) u_mask (
        .width_code (width_code),
        .ia_mask    (ia_mask)
    );

    ars_lad_compare #(
        .DATA_W (DATA_W)
    ) u_lad (
        .bus_data  (bus_data),
        .lad_value (lad_value),
        .ia_mask   (ia_mask),
        .lad_match (lad_match)
    );

    ars_geo_check #(
        .GA_W  (GA_W),
        .CHK_W (GEO_CHK_W)
    ) u_geo (
        .enable   (is_lower),
        .data_low (bus_data[GEO_CHK_W-1:0]),
        .geo_addr (geo_addr),
        .geo_hit  (geo_match)
    );

    ars_class_select #(
        .SEL_W (CLS_SEL_W)
    ) u_cls (
        .enable     (is_lower),
        .sel        (bus_data[CLS_SEL_MSB:CLS_SEL_LSB]),
        .class_bits (class_bits),
        .hit_n      (class_hit_n)
    );

endmodule

// File: rtl/addr_recog_slice_chk.sv
// Module: addr_recog_slice_chk
// Assertion checker for addr_recog_slice. It is attached with bind and observes ports only.
// Assumes: all inputs are known values. The checks are immediate, because the slice has no clock.
module addr_recog_slice_chk #(
    parameter int DATA_W      = 16,
    parameter int CODE_W      = 5,
    parameter int GA_W        = 5,
    parameter int GEO_CHK_W   = 8,
    parameter int CLS_SEL_W   = 4,
    parameter int CLS_SEL_LSB = 4
) (
    input logic                    slice_upper,
    input logic [DATA_W-1:0]       bus_data,
    input logic [CODE_W-1:0]       width_code,
    input logic [GA_W-1:0]         geo_addr,
    input logic [DATA_W-1:0]       lad_value,
    input logic [2**CLS_SEL_W-1:0] class_bits,
    input logic                    lad_match,
    input logic                    geo_match,
    input logic                    class_hit_n
);

    localparam int CLS_SEL_MSB = CLS_SEL_LSB + CLS_SEL_W - 1;

    // Evaluate the port relations whenever any input or output moves.
    always_comb begin
        // R1
        exact_cmp_chk: assert (width_code != '0 || lad_match == (bus_data == lad_value))
            else $error("width 0 compare mismatch");
        // R3
        full_ia_chk: assert (32'(width_code) < DATA_W || lad_match)
            else $error("all-internal width did not match");
        // R4
        top_bit_chk: assert (32'(width_code) >= DATA_W || !lad_match
                             || bus_data[DATA_W-1] == lad_value[DATA_W-1])
            else $error("match despite differing top bit");
        // R5
        geo_pad_chk: assert (!geo_match || (bus_data[GEO_CHK_W-1:GA_W] == '0
                             && bus_data[GA_W-1:0] == geo_addr))
            else $error("geographic hit on wrong data");
        // R6
        upper_geo_chk: assert (!slice_upper || !geo_match)
            else $error("upper slice raised geographic hit");
        // R7
        class_src_chk: assert (class_hit_n || class_bits[bus_data[CLS_SEL_MSB:CLS_SEL_LSB]])
            else $error("class hit with selected bit clear");
        // R8
        upper_class_chk: assert (!slice_upper || class_hit_n)
            else $error("upper slice raised class hit");
    end

endmodule

bind addr_recog_slice addr_recog_slice_chk #(
    .DATA_W      (DATA_W),
    .CODE_W      (CODE_W),
    .GA_W        (GA_W),
    .GEO_CHK_W   (GEO_CHK_W),
    .CLS_SEL_W   (CLS_SEL_W),
    .CLS_SEL_LSB (CLS_SEL_LSB)
) u_chk (.*);

// File: tb/addr_recog_slice_bench.sv
// Directed bench for addr_recog_slice: a lower and an upper slice side by side.
module addr_recog_slice_bench;

    logic clk;
    initial clk = 1'b0;
    always #2 clk = ~clk;

    int n_vec = 0;
    int n_bad = 0;

    logic [15:0] bus_lo, bus_hi, lad_lo, lad_hi, cls;
    logic [4:0]  wc_lo, wc_hi, geo;
    logic        m_lo, m_hi, g_lo, g_hi, c_lo, c_hi;

    addr_recog_slice u_addr_recog_slice (
        .slice_upper (1'b0),
        .bus_data    (bus_lo),
        .width_code  (wc_lo),
        .geo_addr    (geo),
        .lad_value   (lad_lo),
        .class_bits  (cls),
        .lad_match   (m_lo),
        .geo_match   (g_lo),
        .class_hit_n (c_lo)
    );

    addr_recog_slice u_addr_recog_slice_hi (
        .slice_upper (1'b1),
        .bus_data    (bus_hi),
        .width_code  (wc_hi),
        .geo_addr    (geo),
        .lad_value   (lad_hi),
        .class_bits  (cls),
        .lad_match   (m_hi),
        .geo_match   (g_hi),
        .class_hit_n (c_hi)
    );

    // Reference model: the low w bits are ignored, saturating at 16.
    function automatic logic exp_match(logic [15:0] b, logic [15:0] l, logic [4:0] w);
        logic [15:0] m = '0;
        for (int i = 0; i < 16; i++) if (i < int'(w)) m[i] = 1'b1;
        return ((b ^ l) & ~m) == 16'h0;
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // Drive on the rising edge, then wait for the falling edge to sample.
    task automatic drive(logic [15:0] b, logic [15:0] l, logic [4:0] w);
        @(posedge clk);
        bus_lo = b; lad_lo = l; wc_lo = w;
        bus_hi = b; lad_hi = l; wc_hi = w;
        @(negedge clk);
    endtask

    task automatic t_idle();
        geo = '0; cls = '0;
        drive(16'h0, 16'h0, 5'd0);
        chk("R1 idle lad", m_lo, 1);
        chk("R5 idle geo lower", g_lo, 1);
        chk("R7 idle class lower", c_lo, 1);
        chk("R6 idle geo upper", g_hi, 0);
    endtask

    task automatic t_width_zero();
        drive(16'hA5C3, 16'hA5C3, 5'd0); chk("R1 equal", m_lo, 1);
        drive(16'hA5C2, 16'hA5C3, 5'd0); chk("R1 bit0 differs", m_lo, 0);
        drive(16'h25C3, 16'hA5C3, 5'd0); chk("R1 bit15 differs", m_lo, 0);
    endtask

    task automatic t_width_partial();
        for (int w = 1; w < 16; w++) begin
            logic [15:0] base = 16'h3C69 ^ 16'(w * 16'h1111);
            drive(base ^ (16'h1 << (w - 1)), base, 5'(w));
            chk("R2 top ignored bit", m_lo, 1);
            drive(base ^ (16'h1 << w), base, 5'(w));
            chk("R2 lowest compared bit", m_lo, 0);
        end
        drive(16'h123F, 16'h1230, 5'd4); chk("R2 code4 low nibble ignored", m_lo, 1);
        drive(16'h1330, 16'h1230, 5'd4); chk("R2 code4 bit8 compared", m_lo, 0);
    endtask

    task automatic t_width_full();
        for (int w = 16; w < 32; w++) begin
            drive(16'(w * 16'h0F3B), ~16'(w * 16'h0F3B), 5'(w));
            chk("R3 all internal", m_lo, 1);
        end
    endtask

    task automatic t_model();
        for (int k = 0; k < 300; k++) begin
            logic [15:0] l = 16'($urandom);
            logic [15:0] b = l ^ (16'h1 << ($urandom % 16)) ^ ((k % 3 == 0) ? 16'($urandom) : 16'h0);
            logic [4:0]  w = 5'($urandom % 20);
            drive(b, l, w);
            chk("R4 model lower", m_lo, exp_match(b, l, w));
            chk("R9 upper same compare", m_hi, exp_match(b, l, w));
        end
    endtask

    task automatic t_geo();
        for (int g = 0; g < 32; g++) begin
            geo = 5'(g);
            drive({8'($urandom), 3'b000, 5'(g)}, 16'h0, 5'd0);
            chk("R5 geo hit", g_lo, 1);
            chk("R6 upper no geo", g_hi, 0);
        end
        geo = 5'd9;
        drive(16'h0029, 16'h0, 5'd0); chk("R5 bit5 set", g_lo, 0);
        drive(16'h0089, 16'h0, 5'd0); chk("R5 bit7 set", g_lo, 0);
        drive(16'h0008, 16'h0, 5'd0); chk("R5 addr differs", g_lo, 0);
        drive(16'hFF09, 16'h0, 5'd0); chk("R5 high byte ignored", g_lo, 1);
    endtask

    task automatic t_class();
        for (int s = 0; s < 16; s++) begin
            cls = 16'h1 << s;
            drive(16'(s << 4), 16'h0, 5'd0);
            chk("R7 selected set", c_lo, 0);
            chk("R8 upper inactive", c_hi, 1);
            cls = ~(16'h1 << s);
            drive(16'(s << 4) | 16'hF00F, 16'h0, 5'd0);
            chk("R7 selected clear", c_lo, 1);
        end
    endtask

    task automatic t_cascade();
        @(posedge clk);
        wc_lo = 5'd0; wc_hi = 5'd0;
        bus_lo = 16'h1234; lad_lo = 16'h1234; bus_hi = 16'hBEEF; lad_hi = 16'hBEEE;
        @(negedge clk); chk("R9 wired-or lower only", m_lo | m_hi, 1);
        @(posedge clk); bus_lo = 16'h1235; bus_hi = 16'hBEEE;
        @(negedge clk); chk("R9 wired-or upper only", m_lo | m_hi, 1);
        @(posedge clk); bus_hi = 16'hBEEF;
        @(negedge clk); chk("R9 wired-or neither", m_lo | m_hi, 0);
    endtask

    initial begin
        bus_lo = '0; bus_hi = '0; lad_lo = '0; lad_hi = '0;
        wc_lo = '0; wc_hi = '0; geo = '0; cls = '0;
        t_idle();
        t_width_zero();
        t_width_partial();
        t_width_full();
        t_model();
        t_geo();
        t_class();
        t_cascade();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule